// File: doc/BRIEF.md
# Compressed-Row Sparse Matrix Record Streamer

This block walks a sparse matrix stored in compressed-row form and turns it into a stream of element records. Each record carries one nonzero value, its row number and its column number. The matrix sits in three external arrays: nonzero values, the column index of each nonzero, and the start position of each row within the value array. The block reads them through asynchronous read ports. Its address outputs drive the arrays, and the data comes back in the same cycle.

A one-cycle start pulse begins a pass. The row count and the total nonzero count are captured when that pulse is taken. The block derives each row's length from the start positions, skips rows that hold nothing, and presents the records in stored order on a valid/ready output. The record at the last stored position carries a last flag. A one-cycle done pulse closes the pass. Every index and position is 1-based.

Top module: `sparse_row_walker`

## Requirements
- R1: After reset, `out_valid`, `busy` and `done` are low.
- R2: A pass presents the stored positions 1 to `nnz_total` in increasing order, one record each. Each record carries the value and the column read at that position, and the row whose range holds that position. `elem_addr` shows the 1-based position of the record on offer.
- R3: For a row r below the row count, the length is the start entry of row r+1 minus the start entry of row r.
- R4: The length of the final row n is `nnz_total` + 1 minus the start entry of row n.
- R5: A row of length zero produces no record, and the pass continues with the next row.
- R6: While `out_valid` is high and `out_ready` is low, the record fields and `elem_addr` hold their values into the next cycle.
- R7: `out_last` is high exactly on the record whose position equals the captured `nnz_total`, and no record follows it in that pass.
- R8: `done` is high for exactly one cycle per pass. When the final row is not empty, that cycle is the one right after the final record is accepted.
- R9: A start with a row count of zero produces no record, and `done` is high in the cycle after the start is taken.
- R10: A start pulse that arrives while a pass is running has no effect. The pass keeps the row count and nonzero count it captured at its own start.
- R11: `ptr_addr` and `elem_addr` use 1-based addresses. Row numbers on `out_row` run from 1 to the row count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a pass when the block is idle |
| n_rows | input | IDX_W | Number of rows, captured at start |
| nnz_total | input | IDX_W | Total stored nonzeros, captured at start |
| ptr_addr | output | IDX_W | Row number whose start entry is read |
| ptr_data | input | IDX_W | Start position of the addressed row |
| elem_addr | output | IDX_W | Position read from the value and column arrays |
| val_data | input | VAL_W | Value at `elem_addr` |
| col_data | input | IDX_W | Column index at `elem_addr` |
| out_valid | output | 1 | A record is on offer |
| out_ready | input | 1 | The consumer takes the record |
| out_row | output | IDX_W | Row number of the record |
| out_col | output | IDX_W | Column number of the record |
| out_val | output | VAL_W | Nonzero value of the record |
| out_last | output | 1 | The record is the final stored element |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
Two events can fall in the same cycle. One is the acceptance of a row's final record, which also advances the row number and makes the next length lookup the following step. The other is a stray start pulse on a running block. The bench applies backpressure patterns that land acceptance on row ends, pulses start with a different row count in the middle of a pass, and checks that every later record still has the row number the bench computed itself and that the pass ends with its original length. Matrices with leading, inner and trailing empty rows test whether skipping a row and closing the pass happen in the right cycle.

// File: rtl/spw_pkg.sv
package spw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRIME,
    S_LEN,
    S_EMIT,
    S_DONE
  } walk_state_t;

  // Length of a half-open span [first, end_excl); a malformed span gives zero.
  function automatic int span_len(input int end_excl, input int first);
    return (end_excl > first) ? (end_excl - first) : 0;
  endfunction

endpackage

// File: rtl/row_span_unit.sv
module row_span_unit #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] row,
  input  logic [IDX_W-1:0] row_count,
  input  logic [IDX_W-1:0] nnz_count,
  input  logic [IDX_W-1:0] cur_start,
  input  logic [IDX_W-1:0] next_start,
  output logic             final_row,
  output logic [IDX_W-1:0] end_pos,
  output logic [IDX_W-1:0] row_len
);
  import spw_pkg::*;

  always_comb begin
    final_row = (row == row_count);
    // The final row ends just past the last stored nonzero.
    end_pos   = final_row ? IDX_W'(nnz_count + 1'b1) : next_start;
    row_len   = IDX_W'(span_len(int'(end_pos), int'(cur_start)));
  end

endmodule

// File: rtl/elem_cursor.sv
module elem_cursor #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_pos,
  input  logic [IDX_W-1:0] load_len,
  input  logic             step,
  output logic [IDX_W-1:0] pos,
  output logic             at_tail
);
  logic [IDX_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      remain <= '0;
    end else if (load) begin
      pos    <= load_pos;
      remain <= load_len;
    end else if (step) begin
      pos    <= pos + 1'b1;
      remain <= remain - 1'b1;
    end
  end

  assign at_tail = (remain == IDX_W'(1));

endmodule

// File: rtl/sparse_row_walker.sv
module sparse_row_walker #(
  parameter int VAL_W = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] n_rows,
  input  logic [IDX_W-1:0] nnz_total,
  output logic [IDX_W-1:0] ptr_addr,
  input  logic [IDX_W-1:0] ptr_data,
  output logic [IDX_W-1:0] elem_addr,
  input  logic [VAL_W-1:0] val_data,
  input  logic [IDX_W-1:0] col_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_row,
  output logic [IDX_W-1:0] out_col,
  output logic [VAL_W-1:0] out_val,
  output logic             out_last,
  output logic             busy,
  output logic             done
);
  import spw_pkg::*;

  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(1);

  walk_state_t      state;
  logic [IDX_W-1:0] row;
  logic [IDX_W-1:0] rows_q;
  logic [IDX_W-1:0] nnz_q;
  logic [IDX_W-1:0] cur_start;

  logic             final_row;
  logic [IDX_W-1:0] end_pos;
  logic [IDX_W-1:0] row_len;
  logic [IDX_W-1:0] cur_pos;
  logic             at_tail;

  // Named internal events.
  logic ev_take_start;
  logic ev_accept;
  logic ev_row_load;
  logic ev_row_skip;
  logic ev_row_end;

  assign ev_take_start = (state == S_IDLE) && start;
  assign ev_accept     = (state == S_EMIT) && out_ready;
  assign ev_row_load   = (state == S_LEN) && (row_len != '0);
  assign ev_row_skip   = (state == S_LEN) && (row_len == '0);
  assign ev_row_end    = ev_accept && at_tail;

  row_span_unit #(.IDX_W(IDX_W)) u_span (
    .row        (row),
    .row_count  (rows_q),
    .nnz_count  (nnz_q),
    .cur_start  (cur_start),
    .next_start (ptr_data),
    .final_row  (final_row),
    .end_pos    (end_pos),
    .row_len    (row_len)
  );

  elem_cursor #(.IDX_W(IDX_W)) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_row_load),
    .load_pos (cur_start),
    .load_len (row_len),
    .step     (ev_accept),
    .pos      (cur_pos),
    .at_tail  (at_tail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      row       <= '0;
      rows_q    <= '0;
      nnz_q     <= '0;
      cur_start <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          rows_q <= n_rows;
          nnz_q  <= nnz_total;
          row    <= FIRST_IDX;
          state  <= (n_rows == '0) ? S_DONE : S_PRIME;
        end
        S_PRIME: begin
          cur_start <= ptr_data;
          state     <= S_LEN;
        end
        S_LEN: begin
          cur_start <= end_pos;
          if (row_len != '0)  state <= S_EMIT;
          else if (final_row) state <= S_DONE;
          else                row   <= row + 1'b1;
        end
        S_EMIT: if (ev_row_end) begin
          if (final_row) state <= S_DONE;
          else begin
            row   <= row + 1'b1;
            state <= S_LEN;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // The first start entry is read in PRIME; later reads fetch row+1.
  assign ptr_addr  = (state == S_PRIME) ? FIRST_IDX
                   : (final_row ? row : IDX_W'(row + 1'b1));
  assign elem_addr = cur_pos;
  assign out_valid = (state == S_EMIT);
  assign out_row   = row;
  assign out_col   = col_data;
  assign out_val   = val_data;
  assign out_last  = (state == S_EMIT) && (cur_pos == nnz_q);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);

endmodule

// File: rtl/sparse_row_walker_checks.sv
module sparse_row_walker_checks #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [IDX_W-1:0] elem_addr,
  input logic [IDX_W-1:0] out_row,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic             busy,
  input logic             done
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && !done);

  p_pos_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid || (elem_addr != $past(elem_addr)));

  p_hold_record_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(elem_addr) && $stable(out_row));

  p_nothing_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && start |=> busy);

  p_one_based_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (elem_addr != '0) && (out_row != '0));

endmodule

bind sparse_row_walker sparse_row_walker_checks #(.IDX_W(IDX_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .elem_addr (elem_addr),
  .out_row   (out_row),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .busy      (busy),
  .done      (done)
);

// File: tb/test_sparse_row_walker.sv
module test_sparse_row_walker;
  localparam int VAL_W = 16;
  localparam int IDX_W = 8;

  // 5x5 reference matrix: {row, col, value} per stored position, in order.
  localparam int MAIN_N = 8;
  localparam logic [31:0] MAIN_TAB [MAIN_N] = '{
    {8'd1, 8'd1, 16'd4}, {8'd1, 8'd3, 16'd8},
    {8'd2, 8'd1, 16'd6}, {8'd2, 8'd3, 16'd3},
    {8'd3, 8'd2, 16'd1}, {8'd4, 8'd4, 16'd5},
    {8'd5, 8'd1, 16'd7}, {8'd5, 8'd5, 16'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [IDX_W-1:0] n_rows = '0;
  logic [IDX_W-1:0] nnz_total = '0;
  logic [IDX_W-1:0] ptr_addr, ptr_data, elem_addr, col_data;
  logic [VAL_W-1:0] val_data;
  logic out_valid, out_last, busy, done;
  logic out_ready = 1'b0;
  logic [IDX_W-1:0] out_row, out_col;
  logic [VAL_W-1:0] out_val;

  logic [IDX_W-1:0] pmem [0:15];
  logic [IDX_W-1:0] cmem [0:15];
  logic [VAL_W-1:0] vmem [0:15];

  logic [IDX_W-1:0] exp_row [0:31];
  logic [IDX_W-1:0] exp_col [0:31];
  logic [VAL_W-1:0] exp_val [0:31];
  int exp_n;
  bit last_row_full;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  always_comb begin
    ptr_data = pmem[ptr_addr[3:0]];
    col_data = cmem[elem_addr[3:0]];
    val_data = vmem[elem_addr[3:0]];
  end

  sparse_row_walker #(.VAL_W(VAL_W), .IDX_W(IDX_W)) i_sparse_row_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .n_rows(n_rows),
    .nnz_total(nnz_total), .ptr_addr(ptr_addr), .ptr_data(ptr_data),
    .elem_addr(elem_addr), .val_data(val_data), .col_data(col_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
    .out_col(out_col), .out_val(out_val), .out_last(out_last),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) begin
      pmem[i] = '0; cmem[i] = '0; vmem[i] = '0;
    end
  endtask

  // Expected records derived from the start entries (R3, R4, R5).
  task automatic build_exp(input int n, input int nnz);
    exp_n = 0;
    last_row_full = 0;
    for (int r = 1; r <= n; r++) begin
      int s = int'(pmem[r]);
      int e = (r == n) ? nnz + 1 : int'(pmem[r + 1]);
      if (r == n) last_row_full = (e > s);
      for (int k = s; k < e; k++) begin
        exp_row[exp_n] = IDX_W'(r);
        exp_col[exp_n] = cmem[k];
        exp_val[exp_n] = vmem[k];
        exp_n++;
      end
    end
  endtask

  task automatic load_main();
    clear_mem();
    pmem[1] = 8'd1; pmem[2] = 8'd3; pmem[3] = 8'd5; pmem[4] = 8'd6; pmem[5] = 8'd7;
    for (int i = 0; i < MAIN_N; i++) begin
      cmem[i + 1]    = MAIN_TAB[i][23:16];
      vmem[i + 1]    = MAIN_TAB[i][15:0];
      exp_row[i]     = MAIN_TAB[i][31:24];
      exp_col[i]     = MAIN_TAB[i][23:16];
      exp_val[i]     = MAIN_TAB[i][15:0];
    end
    exp_n = MAIN_N;
    last_row_full = 1;
  endtask

  task automatic load_lengths(input int n, input int lens [8]);
    int p = 1;
    clear_mem();
    for (int r = 1; r <= n; r++) begin
      pmem[r] = IDX_W'(p);
      p += lens[r - 1];
    end
    for (int k = 1; k < 16; k++) begin
      cmem[k] = IDX_W'((k * 5) % 7 + 1);
      vmem[k] = VAL_W'(16'h100 + k * 3);
    end
  endtask

  function automatic bit ready_pat(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return (c % 2) == 0;
      default: return (c % 3) == 2;
    endcase
  endfunction

  // Runs one pass; poke >= 0 pulses a stray start at that cycle (R10).
  task automatic run_pass(input int n, input int nnz, input int mode, input int poke);
    int got = 0, dones = 0, cyc = 0, last_acc = -10;
    bit stalled = 0;
    logic [IDX_W-1:0] h_row, h_col, h_addr;
    logic [VAL_W-1:0] h_val;
    @(negedge clk);
    n_rows = IDX_W'(n); nnz_total = IDX_W'(nnz); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cyc < 300 && dones == 0) begin
      out_ready = ready_pat(mode, cyc);
      if (cyc == poke) begin
        start = 1'b1; n_rows = 8'd1; nnz_total = 8'd1;
      end else begin
        start = 1'b0;
      end
      #1;
      if (stalled) begin
        check(out_valid && out_row == h_row && out_col == h_col &&
              out_val == h_val && elem_addr == h_addr,
              "R6", "held record address", longint'(elem_addr), longint'(h_addr));
      end
      if (out_valid && out_ready) begin
        if (got < exp_n) begin
          check(out_row == exp_row[got], (got > 0 && exp_row[got] != exp_row[got-1]) ? "R3" : "R2",
                "record row", longint'(out_row), longint'(exp_row[got]));
          check(out_col == exp_col[got] && out_val == exp_val[got], "R2",
                "record value", longint'(out_val), longint'(exp_val[got]));
          check(out_last == (got == exp_n - 1), "R7", "last flag",
                longint'(out_last), longint'(got == exp_n - 1));
        end else begin
          check(0, "R5", "extra record count", longint'(got + 1), longint'(exp_n));
        end
        got++;
        last_acc = cyc;
      end
      stalled = out_valid && !out_ready;
      h_row = out_row; h_col = out_col; h_val = out_val; h_addr = elem_addr;
      if (done) begin
        dones++;
        if (n == 0)
          check(cyc == 0, "R9", "done cycle after start", longint'(cyc), 0);
        else if (last_row_full)
          check(last_acc == cyc - 1, "R8", "done after final accept",
                longint'(last_acc), longint'(cyc - 1));
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    out_ready = 1'b0;
    check(got == exp_n, (poke >= 0) ? "R10" : "R5", "record count",
          longint'(got), longint'(exp_n));
    check(dones == 1, "R8", "done seen", longint'(dones), 1);
    #1;
    check(!done && !busy, "R8", "done single pulse", longint'(done), 0);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    int lens_a [8] = '{0, 3, 0, 1, 0, 2, 0, 0};
    int lens_b [8] = '{2, 0, 1, 0, 0, 0, 0, 0};
    int lens_c [8] = '{0, 0, 4, 0, 0, 0, 0, 0};
    clear_mem();
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !busy && !done, "R1", "reset outputs",
          longint'({out_valid, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table-driven reference matrix under three backpressure patterns.
    for (int m = 0; m < 3; m++) begin
      load_main();
      run_pass(5, 8, m, -1);
    end

    // R3, R4, R5: leading, inner and empty rows, final row non-empty.
    load_lengths(6, lens_a);
    build_exp(6, 6);
    run_pass(6, 6, 1, -1);

    // R5, R8: trailing empty rows, done follows the skips.
    load_lengths(4, lens_b);
    build_exp(4, 3);
    run_pass(4, 3, 0, -1);

    // R4: only the final row holds elements; length from the total count.
    load_lengths(3, lens_c);
    build_exp(3, 4);
    run_pass(3, 4, 2, -1);

    // R9: zero rows.
    load_main();
    exp_n = 0;
    last_row_full = 0;
    run_pass(0, 0, 0, -1);

    // R10: stray start mid-pass with different counts.
    load_main();
    run_pass(5, 8, 1, 4);

    // R11: first address presented for a pass is position 1.
    load_main();
    @(negedge clk);
    n_rows = 8'd5; nnz_total = 8'd8; start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk); @(negedge clk);
    #1;
    check(out_valid && elem_addr == 8'd1 && out_row == 8'd1, "R11",
          "first position", longint'(elem_addr), 1);
    out_ready = 1'b1;
    repeat (20) @(negedge clk);
    out_ready = 1'b0;
    #1;
    check(!busy, "R8", "pass finished", longint'(busy), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule